// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a shared memory that two agents reach through two independent ports, called left and right. Each port has its own address, write data, read data and active-low chip-enable, output-enable and write-enable controls. Either port can read or write any word at any time. Both ports run on one clock. A read returns its data on the clock edge after the access. The word count is `2**ADDR_W`, so `ADDR_W = 13` gives 8K words. `DATA_W` is meant to be 8 or 9 bits.

The two highest addresses also act as doorbells between the ports. A left write to the highest address (all ones) raises the right port's active-low interrupt. The right port clears that interrupt by reading the same word. The address one below (all ones except bit 0) works the same way in the other direction: a right write raises the left interrupt, and a left read clears it.

A mode input decides how the busy flags work.
- In master mode, the block compares the two addresses itself. On a match it drives a busy flag to the right port, which loses every tie, and the right port's write is suppressed.
- In slave mode, the block drives no busy flag. Instead it takes an external busy input per port, and that input blocks the port's writes.

Top module: `dpMailboxRam`

## Requirements
- R1: A word written by either port is stored at its address and can be read back by either port. Read data appears one clock edge after the read access. A read in the same cycle as a write to that word returns the value held before that edge.
- R2: A port performs an access only while its `CeN` is 0. With `CeN` = 0, `WeN` = 0 selects a write and `WeN` = 1 selects a read. With `CeN` = 1 nothing is written, whatever `WeN` is.
- R3: A stored left-port write to the all-ones address drives `rIntN` to 0 from the next cycle. A right-port read of that address (`CeN` = 0, `WeN` = 1, regardless of `OeN`) returns `rIntN` to 1 on the next cycle. If a set and a clear happen in the same cycle, the set wins. A right-port write to that address leaves `rIntN` unchanged.
- R4: A stored right-port write to the all-ones-except-bit-0 address drives `lIntN` to 0 from the next cycle. A left-port read of that address returns `lIntN` to 1. If a set and a clear happen in the same cycle, the set wins.
- R5: In master mode (`msSel` = 1), when both ports have `CeN` = 0 and equal addresses, `rBusyOutN` is 0 in that same cycle. In that case the right write is not stored, the left write is stored, and a right read still returns the value held before the edge.
- R6: `lBusyOutN` is always 1. `rBusyOutN` returns to 1 in the first cycle in which the addresses no longer match. In slave mode (`msSel` = 0), both busy outputs stay 1.
- R7: In slave mode, `xBusyInN` = 0 prevents that port's write from being stored. In master mode, the busy inputs have no effect.
- R8: `xRvalid` is 1 in the cycle after an edge at which that port had `CeN` = 0, `WeN` = 1 and `OeN` = 0. It is 0 after any other edge and during reset.
- R9: A mailbox write that is suppressed by contention or by a busy input does not set the interrupt.
- R10: In slave mode, when both ports write the same word in the same cycle, the left value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| msSel | input | 1 | 1 = master (busy generated), 0 = slave (busy received) |
| lCeN | input | 1 | Left chip enable, active low |
| lOeN | input | 1 | Left output enable, active low |
| lWeN | input | 1 | Left write enable, active low |
| lAddr | input | ADDR_W | Left address |
| lWdata | input | DATA_W | Left write data |
| lBusyInN | input | 1 | Left busy input (slave mode) |
| lRdata | output | DATA_W | Left read data |
| lRvalid | output | 1 | Left read data is being driven |
| lBusyOutN | output | 1 | Left busy output |
| lIntN | output | 1 | Left mailbox interrupt, active low |
| rCeN | input | 1 | Right chip enable, active low |
| rOeN | input | 1 | Right output enable, active low |
| rWeN | input | 1 | Right write enable, active low |
| rAddr | input | ADDR_W | Right address |
| rWdata | input | DATA_W | Right write data |
| rBusyInN | input | 1 | Right busy input (slave mode) |
| rRdata | output | DATA_W | Right read data |
| rRvalid | output | 1 | Right read data is being driven |
| rBusyOutN | output | 1 | Right busy output |
| rIntN | output | 1 | Right mailbox interrupt, active low |

## Verification
A write strobe that wrongly escapes suppression shows up on the next read of that word from either port: the value is replaced by the losing port's data. A wrong interrupt flag shows up on `lIntN` or `rIntN` one cycle after the mailbox access that should have changed it. A stale or mis-set valid register is visible on the first read cycle, because valid and data are updated on the same edge. The bench sweeps every address of a 32-word configuration from both ports, then forces each contention, busy-input and mailbox set/clear collision and checks the outputs in the cycle each one is due.

// File: rtl/dpmbPkg.sv
package dpmbPkg;
  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic lWr;    // store left write data
    logic rWr;    // store right write data
    logic lRd;    // left read access
    logic rRd;    // right read access
    logic lShow;  // left read with output enabled
    logic rShow;  // right read with output enabled
  } dpmbStrobe_t;
endpackage

// File: rtl/dpmbControl.sv
module dpmbControl
  import dpmbPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msSel,
  input  logic              lCeN,
  input  logic              lOeN,
  input  logic              lWeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyInN,
  input  logic              rCeN,
  input  logic              rOeN,
  input  logic              rWeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyInN,
  output dpmbStrobe_t       st,
  output logic              lBusyOutN,
  output logic              rBusyOutN,
  output logic              lIntN,
  output logic              rIntN
);
  localparam logic [ADDR_W-1:0] RIGHT_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LEFT_BOX  = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic lAcc, rAcc, clash, lBlock, rBlock;
  logic lPend, rPend;
  logic lSet, lClr, rSet, rClr;

  assign lAcc  = !lCeN;
  assign rAcc  = !rCeN;
  // Master mode: right port loses every address tie
  assign clash = msSel && lAcc && rAcc && (lAddr == rAddr);

  assign lBlock = !msSel && !lBusyInN;
  assign rBlock = clash || (!msSel && !rBusyInN);

  always_comb begin
    st       = '0;
    st.lWr   = lAcc && !lWeN && !lBlock;
    st.rWr   = rAcc && !rWeN && !rBlock;
    st.lRd   = lAcc && lWeN;
    st.rRd   = rAcc && rWeN;
    st.lShow = lAcc && lWeN && !lOeN;
    st.rShow = rAcc && rWeN && !rOeN;
  end

  assign lBusyOutN = 1'b1;
  assign rBusyOutN = !clash;

  // Mailbox doorbells: set by the opposite port's stored write, cleared by own read
  assign rSet = st.lWr && (lAddr == RIGHT_BOX);
  assign rClr = st.rRd && (rAddr == RIGHT_BOX);
  assign lSet = st.rWr && (rAddr == LEFT_BOX);
  assign lClr = st.lRd && (lAddr == LEFT_BOX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lPend <= 1'b0;
      rPend <= 1'b0;
    end else begin
      if (rSet)      rPend <= 1'b1;
      else if (rClr) rPend <= 1'b0;
      if (lSet)      lPend <= 1'b1;
      else if (lClr) lPend <= 1'b0;
    end
  end

  assign lIntN = !lPend;
  assign rIntN = !rPend;

  // R5: a busy right port never stores its write
  a_r5_busy_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    !rBusyOutN |-> !st.rWr);
  // R6: no busy output in slave mode
  a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !msSel |-> rBusyOutN);
  // R7: slave-mode busy input blocks the left write
  a_r7_slave_block: assert property (@(posedge clk) disable iff (!rstN)
    (!msSel && !lBusyInN) |-> !st.lWr);
  // R3: left mailbox write raises the right interrupt
  a_r3_int_set: assert property (@(posedge clk) disable iff (!rstN)
    (st.lWr && lAddr == RIGHT_BOX) |=> !rIntN);
  // R3: right read of its mailbox clears it when no set collides
  a_r3_int_clear: assert property (@(posedge clk) disable iff (!rstN)
    (st.rRd && rAddr == RIGHT_BOX && !(st.lWr && lAddr == RIGHT_BOX)) |=> rIntN);
  // R4: right mailbox write raises the left interrupt
  a_r4_int_set: assert property (@(posedge clk) disable iff (!rstN)
    (st.rWr && rAddr == LEFT_BOX) |=> !lIntN);
endmodule

// File: rtl/dpmbDatapath.sv
module dpmbDatapath
  import dpmbPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpmbStrobe_t       st,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic              lRvalid,
  output logic [DATA_W-1:0] rRdata,
  output logic              rRvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right write first, left second: left value wins a same-word collision
  always_ff @(posedge clk) begin
    if (st.rWr) mem[rAddr] <= rWdata;
    if (st.lWr) mem[lAddr] <= lWdata;
  end

  // Read-first registered read data
  always_ff @(posedge clk) begin
    if (st.lRd) lRdata <= mem[lAddr];
    if (st.rRd) rRdata <= mem[rAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lRvalid <= 1'b0;
      rRvalid <= 1'b0;
    end else begin
      lRvalid <= st.lShow;
      rRvalid <= st.rShow;
    end
  end

  // R8: valid follows an enabled read, one edge later
  a_r8_left_valid_on: assert property (@(posedge clk) disable iff (!rstN)
    st.lShow |=> lRvalid);
  a_r8_right_valid_off: assert property (@(posedge clk) disable iff (!rstN)
    !st.rShow |=> !rRvalid);
endmodule

// File: rtl/dpMailboxRam.sv
module dpMailboxRam
  import dpmbPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msSel,
  input  logic              lCeN,
  input  logic              lOeN,
  input  logic              lWeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  input  logic              lBusyInN,
  output logic [DATA_W-1:0] lRdata,
  output logic              lRvalid,
  output logic              lBusyOutN,
  output logic              lIntN,
  input  logic              rCeN,
  input  logic              rOeN,
  input  logic              rWeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  input  logic              rBusyInN,
  output logic [DATA_W-1:0] rRdata,
  output logic              rRvalid,
  output logic              rBusyOutN,
  output logic              rIntN
);
  dpmbStrobe_t st;

  dpmbControl #(.ADDR_W(ADDR_W)) u_control (
    .clk(clk), .rstN(rstN), .msSel(msSel),
    .lCeN(lCeN), .lOeN(lOeN), .lWeN(lWeN), .lAddr(lAddr), .lBusyInN(lBusyInN),
    .rCeN(rCeN), .rOeN(rOeN), .rWeN(rWeN), .rAddr(rAddr), .rBusyInN(rBusyInN),
    .st(st), .lBusyOutN(lBusyOutN), .rBusyOutN(rBusyOutN),
    .lIntN(lIntN), .rIntN(rIntN)
  );

  dpmbDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .st(st),
    .lAddr(lAddr), .lWdata(lWdata), .rAddr(rAddr), .rWdata(rWdata),
    .lRdata(lRdata), .lRvalid(lRvalid), .rRdata(rRdata), .rRvalid(rRvalid)
  );
endmodule

// File: tb/dpMailboxRam_bench.sv
module dpMailboxRam_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 9;
  localparam int WORDS = 1 << AW;
  localparam int TOPA = WORDS - 1;
  localparam int LBOX = WORDS - 2;

  logic clk = 1'b0;
  logic rstN, msSel;
  logic lCeN, lOeN, lWeN, lBusyInN, rCeN, rOeN, rWeN, rBusyInN;
  logic [AW-1:0] lAddr, rAddr;
  logic [DW-1:0] lWdata, rWdata, lRdata, rRdata;
  logic lRvalid, rRvalid, lBusyOutN, rBusyOutN, lIntN, rIntN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpMailboxRam #(.ADDR_W(AW), .DATA_W(DW)) u_dpMailboxRam (
    .clk(clk), .rstN(rstN), .msSel(msSel),
    .lCeN(lCeN), .lOeN(lOeN), .lWeN(lWeN), .lAddr(lAddr), .lWdata(lWdata),
    .lBusyInN(lBusyInN), .lRdata(lRdata), .lRvalid(lRvalid),
    .lBusyOutN(lBusyOutN), .lIntN(lIntN),
    .rCeN(rCeN), .rOeN(rOeN), .rWeN(rWeN), .rAddr(rAddr), .rWdata(rWdata),
    .rBusyInN(rBusyInN), .rRdata(rRdata), .rRvalid(rRvalid),
    .rBusyOutN(rBusyOutN), .rIntN(rIntN)
  );

  function automatic logic [DW-1:0] valA(int a);
    return DW'((a * 37 + 5) % 512);
  endfunction
  function automatic logic [DW-1:0] valB(int a);
    return DW'((a * 11 + 200) % 512);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    lCeN = 1'b1; lOeN = 1'b1; lWeN = 1'b1;
    rCeN = 1'b1; rOeN = 1'b1; rWeN = 1'b1;
  endtask

  task automatic lRead(int a);
    idle(); lCeN = 1'b0; lOeN = 1'b0; lAddr = AW'(a); step(); idle();
  endtask

  task automatic rRead(int a);
    idle(); rCeN = 1'b0; rOeN = 1'b0; rAddr = AW'(a); step(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; msSel = 1'b1; lBusyInN = 1'b1; rBusyInN = 1'b1;
    lAddr = '0; rAddr = '0; lWdata = '0; rWdata = '0;
    idle();
    repeat (3) @(negedge clk);
    // Reset state (R3, R4, R8)
    chk("R3 reset rIntN", 16'(rIntN), 16'd1);
    chk("R4 reset lIntN", 16'(lIntN), 16'd1);
    chk("R8 reset lRvalid", 16'(lRvalid), 16'd0);
    chk("R8 reset rRvalid", 16'(rRvalid), 16'd0);
    rstN = 1'b1;
    step();

    // R1: left fills every word
    for (int a = 0; a < WORDS; a++) begin
      idle(); lCeN = 1'b0; lWeN = 1'b0; lOeN = 1'b0; lAddr = AW'(a); lWdata = valA(a);
      step();
      model[a] = valA(a);
      if (a == 0) chk("R8 no valid on write", 16'(lRvalid), 16'd0);
    end
    idle();
    chk("R3 left mailbox write sets rIntN", 16'(rIntN), 16'd0);
    chk("R4 lIntN untouched", 16'(lIntN), 16'd1);

    // R1: right reads every word
    for (int a = 0; a < WORDS; a++) begin
      rRead(a);
      chk("R1 right readback", 16'(rRdata), 16'(model[a]));
      chk("R8 right valid", 16'(rRvalid), 16'd1);
    end
    chk("R3 right mailbox read clears rIntN", 16'(rIntN), 16'd1);

    // R1: right fills every word
    for (int a = 0; a < WORDS; a++) begin
      idle(); rCeN = 1'b0; rWeN = 1'b0; rAddr = AW'(a); rWdata = valB(a);
      step();
      model[a] = valB(a);
    end
    idle();
    chk("R4 right mailbox write sets lIntN", 16'(lIntN), 16'd0);
    chk("R3 right write of own mailbox leaves rIntN", 16'(rIntN), 16'd1);

    for (int a = 0; a < WORDS; a++) begin
      lRead(a);
      chk("R1 left readback", 16'(lRdata), 16'(model[a]));
    end
    chk("R4 left mailbox read clears lIntN", 16'(lIntN), 16'd1);

    // R8: output enable off, and write cycle
    idle(); rCeN = 1'b0; rOeN = 1'b1; rAddr = AW'(4); step();
    chk("R8 oe high gives no valid", 16'(rRvalid), 16'd0);
    idle(); rCeN = 1'b0; rOeN = 1'b0; rWeN = 1'b0; rAddr = AW'(5); rWdata = model[5]; step();
    chk("R8 write gives no valid", 16'(rRvalid), 16'd0);

    // R2: chip enable inactive blocks the write
    idle(); rCeN = 1'b1; rWeN = 1'b0; rAddr = AW'(3); rWdata = 9'h1AA; step();
    lRead(3);
    chk("R2 ce high no write", 16'(lRdata), 16'(model[3]));

    // R5/R6: master contention, both write word 9
    idle();
    lCeN = 1'b0; lWeN = 1'b0; lAddr = AW'(9); lWdata = 9'h055;
    rCeN = 1'b0; rWeN = 1'b0; rAddr = AW'(9); rWdata = 9'h0AA;
    #1;
    chk("R5 right busy on match", 16'(rBusyOutN), 16'd0);
    chk("R6 left never busy", 16'(lBusyOutN), 16'd1);
    step();
    model[9] = 9'h055;
    lWeN = 1'b1; lOeN = 1'b0; rWeN = 1'b1; rAddr = AW'(10);
    #1;
    chk("R6 busy released on mismatch", 16'(rBusyOutN), 16'd1);
    step();
    chk("R5 left write won", 16'(lRdata), 16'(model[9]));

    // R5: right read proceeds under contention with read-first data
    idle();
    lCeN = 1'b0; lWeN = 1'b0; lAddr = AW'(9); lWdata = 9'h123;
    rCeN = 1'b0; rOeN = 1'b0; rAddr = AW'(9);
    step();
    chk("R5 contended right read old data", 16'(rRdata), 16'(model[9]));
    model[9] = 9'h123;
    rRead(9);
    chk("R1 new data after collision", 16'(rRdata), 16'(model[9]));

    // R9: suppressed right mailbox write
    idle();
    lCeN = 1'b0; lOeN = 1'b0; lAddr = AW'(LBOX);
    rCeN = 1'b0; rWeN = 1'b0; rAddr = AW'(LBOX); rWdata = 9'h0F0;
    step();
    chk("R9 suppressed write no lInt", 16'(lIntN), 16'd1);
    lRead(LBOX);
    chk("R9 suppressed word unchanged", 16'(lRdata), 16'(model[LBOX]));

    // R7: busy inputs ignored in master mode
    lBusyInN = 1'b0; rBusyInN = 1'b0;
    idle(); rCeN = 1'b0; rWeN = 1'b0; rAddr = AW'(12); rWdata = 9'h077; step();
    model[12] = 9'h077;
    lRead(12);
    chk("R7 master ignores busy input", 16'(lRdata), 16'(model[12]));
    lBusyInN = 1'b1; rBusyInN = 1'b1;

    // Slave mode: R6, R10, R7
    msSel = 1'b0;
    idle();
    lCeN = 1'b0; lWeN = 1'b0; lAddr = AW'(14); lWdata = 9'h011;
    rCeN = 1'b0; rWeN = 1'b0; rAddr = AW'(14); rWdata = 9'h022;
    #1;
    chk("R6 slave right busy high", 16'(rBusyOutN), 16'd1);
    chk("R6 slave left busy high", 16'(lBusyOutN), 16'd1);
    step();
    model[14] = 9'h011;
    rRead(14);
    chk("R10 slave collision left wins", 16'(rRdata), 16'(model[14]));
    lBusyInN = 1'b0;
    idle(); lCeN = 1'b0; lWeN = 1'b0; lAddr = AW'(15); lWdata = 9'h1FF; step();
    lBusyInN = 1'b1;
    rRead(15);
    chk("R7 slave left busy input blocks", 16'(rRdata), 16'(model[15]));
    rBusyInN = 1'b0;
    idle(); rCeN = 1'b0; rWeN = 1'b0; rAddr = AW'(16); rWdata = 9'h1FE; step();
    rBusyInN = 1'b1;
    lRead(16);
    chk("R7 slave right busy input blocks", 16'(lRdata), 16'(model[16]));

    // R4: set beats clear, slave mode so both proceed
    idle();
    lCeN = 1'b0; lOeN = 1'b0; lAddr = AW'(LBOX);
    rCeN = 1'b0; rWeN = 1'b0; rAddr = AW'(LBOX); rWdata = 9'h1E1;
    step();
    chk("R4 set wins over clear", 16'(lIntN), 16'd0);
    chk("R1 same-cycle read returns old word", 16'(lRdata), 16'(model[LBOX]));
    model[LBOX] = 9'h1E1;
    lRead(LBOX);
    chk("R4 read clears after set", 16'(lIntN), 16'd1);
    chk("R1 mailbox word stored", 16'(lRdata), 16'(model[LBOX]));
    msSel = 1'b1;

    // R3: set beats clear under master contention
    idle();
    lCeN = 1'b0; lWeN = 1'b0; lAddr = AW'(TOPA); lWdata = 9'h0C3;
    rCeN = 1'b0; rOeN = 1'b0; rAddr = AW'(TOPA);
    step();
    chk("R3 set wins over clear", 16'(rIntN), 16'd0);
    model[TOPA] = 9'h0C3;
    rRead(TOPA);
    chk("R3 later read clears", 16'(rIntN), 16'd1);
    chk("R1 top word readback", 16'(rRdata), 16'(model[TOPA]));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule